// File: doc/BRIEF.md
# Lockable Channel Selection Buffer

This block sits between the CPU's register write port and the analog front end of a converter. The CPU writes a 5-bit input-channel code and a 2-bit reference code at any time. The write always lands in a temporary register. A second, effective copy drives the converter. While no conversion is running, the effective copy follows every write on the same clock edge that captures it. The effective copy is frozen while a conversion samples its input, so the selection stays stable for the full sampling and conversion window.

A small state machine controls the lock, and it has three states. In `ST_TRACK` the effective copy is reloaded on every edge. A sampled start request moves it to `ST_ARMED` (transition *arm*). The next edge is the conversion start. At that edge the effective copy takes the temporary value, so a write sampled on that edge still counts, and the machine enters `ST_LOCKED` (transition *lock*). In `ST_LOCKED` the effective copy holds. When the sequencer flags the last cycle of the conversion, or drops its busy indication, the effective copy reloads on that edge and the machine returns to `ST_TRACK` (transition *release*). Otherwise `ST_LOCKED` loops (*hold*) and `ST_TRACK` loops (*idle*). All clocking is on the converter clock.

Top module: `chsel_lock_buf`

## Requirements
- R1: While reset is low and after it is released, the effective channel and reference codes are zero and the block is tracking.
- R2: Every write is captured into the temporary register, whatever the lock state. A write made during a lock becomes visible on the effective outputs when tracking resumes.
- R3: In the tracking state, a write sampled on a rising edge appears on the effective outputs right after that edge.
- R4: A start request sampled on an edge arms the block. The next edge starts the conversion and loads the effective copy with the temporary value, including a write sampled on that same edge.
- R5: From the conversion-start edge until the release edge, the effective outputs do not change, whatever is written.
- R6: On the edge that samples the last-cycle indication while locked, the effective copy reloads with the latest temporary value, including one written in the lock window.
- R7: A write sampled on the release edge is taken. Afterwards every write is tracked again.
- R8: If the busy indication is low while locked, the block releases on that edge in the same way as on the last-cycle indication.
- R9: The channel code (wr_mux, eff_mux, 5 bits) and the reference code (wr_ref, eff_ref, 2 bits) are transferred together in one edge. Neither is ever taken without the other.
- R10: A start request while armed or locked is ignored. A last-cycle indication while tracking is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | CPU write strobe for the selection register |
| wr_mux | input | 5 | Channel code being written |
| wr_ref | input | 2 | Reference code being written |
| start_req | input | 1 | Start bit written by the CPU |
| conv_busy | input | 1 | Sequencer reports a conversion in progress |
| conv_last | input | 1 | Sequencer reports the last cycle before completion |
| eff_mux | output | 5 | Effective channel code to the front end |
| eff_ref | output | 2 | Effective reference code to the front end |

## Verification
The bench sweeps all 128 channel and reference pairs while tracking. It then runs conversions with lock windows of zero to five cycles, writing on every cycle of each window. A design that locked one edge early would lose the write made on the conversion-start edge. A design that released one edge late would show the old value after the last-cycle edge. A design that did not lock at all would show the writes made inside the window. Stray start requests inside the window and a last-cycle flag while idle catch a machine that re-arms or freezes at the wrong time. An aborted conversion with busy dropped catches a design that stays locked forever.

// File: rtl/chsel_pkg.sv
package chsel_pkg;

    typedef enum logic [1:0] {
        ST_TRACK  = 2'd0,
        ST_ARMED  = 2'd1,
        ST_LOCKED = 2'd2
    } lock_state_e;

endpackage

// File: rtl/chsel_shadow_reg.sv
module chsel_shadow_reg #(
    parameter int unsigned SEL_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_data,
    output logic [SEL_W-1:0] tmp_q,
    output logic [SEL_W-1:0] tmp_next
);

    // value the temporary register takes on the coming edge
    always_comb begin
        tmp_next = wr_en ? wr_data : tmp_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmp_q <= '0;
        end else begin
            tmp_q <= tmp_next;
        end
    end

    // R2: any write is captured, regardless of lock
    assert_write_taken_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> tmp_q == $past(wr_data));

endmodule

// File: rtl/chsel_lock_fsm.sv
module chsel_lock_fsm
    import chsel_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_req,
    input  logic        conv_busy,
    input  logic        conv_last,
    output lock_state_e state_q,
    output logic        load_en
);

    lock_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_TRACK:  if (start_req) state_d = ST_ARMED;
            ST_ARMED:  state_d = ST_LOCKED;
            ST_LOCKED: if (conv_last || !conv_busy) state_d = ST_TRACK;
            default:   state_d = ST_TRACK;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_TRACK;
        end else begin
            state_q <= state_d;
        end
    end

    // output process: reload everywhere except inside the lock window
    always_comb begin
        unique case (state_q)
            ST_TRACK:  load_en = 1'b1;
            ST_ARMED:  load_en = 1'b1;
            ST_LOCKED: load_en = conv_last || !conv_busy;
            default:   load_en = 1'b1;
        endcase
    end

    assert_arm_on_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TRACK && start_req) |=> state_q == ST_ARMED);

    assert_lock_after_arm_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ARMED) |=> state_q == ST_LOCKED);

    assert_release_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOCKED && conv_last) |=> state_q == ST_TRACK);

    assert_release_abort_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOCKED && !conv_busy) |=> state_q == ST_TRACK);

    assert_ignore_last_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TRACK && !start_req) |=> state_q == ST_TRACK);

endmodule

// File: rtl/chsel_eff_reg.sv
module chsel_eff_reg #(
    parameter int unsigned SEL_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_en,
    input  logic [SEL_W-1:0] load_data,
    output logic [SEL_W-1:0] eff_q
);

    // single register: both fields move in one edge (R9)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eff_q <= '0;
        end else if (load_en) begin
            eff_q <= load_data;
        end
    end

endmodule

// File: rtl/chsel_lock_buf.sv
module chsel_lock_buf
    import chsel_pkg::*;
#(
    parameter int unsigned MUX_W = 5,
    parameter int unsigned REF_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [MUX_W-1:0] wr_mux,
    input  logic [REF_W-1:0] wr_ref,
    input  logic             start_req,
    input  logic             conv_busy,
    input  logic             conv_last,
    output logic [MUX_W-1:0] eff_mux,
    output logic [REF_W-1:0] eff_ref
);

    localparam int unsigned SEL_W = MUX_W + REF_W;

    logic [SEL_W-1:0] tmp_q;
    logic [SEL_W-1:0] tmp_next;
    logic [SEL_W-1:0] eff_q;
    logic             load_en;
    lock_state_e      state_q;

    chsel_shadow_reg #(.SEL_W(SEL_W)) shadow_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_data  ({wr_ref, wr_mux}),
        .tmp_q    (tmp_q),
        .tmp_next (tmp_next)
    );

    chsel_lock_fsm fsm_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_req (start_req),
        .conv_busy (conv_busy),
        .conv_last (conv_last),
        .state_q   (state_q),
        .load_en   (load_en)
    );

    chsel_eff_reg #(.SEL_W(SEL_W)) eff_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_en   (load_en),
        .load_data (tmp_next),
        .eff_q     (eff_q)
    );

    assign eff_mux = eff_q[MUX_W-1:0];
    assign eff_ref = eff_q[SEL_W-1:MUX_W];

    // R3: outside the lock window the effective copy mirrors the temporary one
    assert_track_equal_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_LOCKED) |-> eff_q == tmp_q);

    // R5: inside the lock window the outputs hold
    assert_hold_locked_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOCKED && conv_busy && !conv_last) |=> $stable(eff_q));

    // R6: the release edge brings in the newest temporary value
    assert_release_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOCKED && conv_last) |=> eff_q == tmp_q);

endmodule

// File: tb/chsel_lock_buf_tb_top.sv
`timescale 1ns/1ps
module chsel_lock_buf_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [4:0] wr_mux = '0;
    logic [1:0] wr_ref = '0;
    logic       start_req = 1'b0;
    logic       conv_busy = 1'b0;
    logic       conv_last = 1'b0;
    logic [4:0] eff_mux;
    logic [1:0] eff_ref;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    chsel_lock_buf dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_mux    (wr_mux),
        .wr_ref    (wr_ref),
        .start_req (start_req),
        .conv_busy (conv_busy),
        .conv_last (conv_last),
        .eff_mux   (eff_mux),
        .eff_ref   (eff_ref)
    );

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string rq, input logic [6:0] exp);
        checks++;
        if ({eff_ref, eff_mux} !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", rq, {eff_ref, eff_mux}, exp);
        end
    endtask

    task automatic wr(input logic [6:0] v);
        wr_en  = 1'b1;
        wr_mux = v[4:0];
        wr_ref = v[6:5];
    endtask

    task automatic no_wr();
        wr_en = 1'b0;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [6:0] a, a2, b, w, exp;
        @(negedge clk);
        wr(7'h5A);
        chk("R1", 7'h00);
        step();
        chk("R1", 7'h00);
        no_wr();
        rst_n = 1'b1;
        step();
        chk("R1", 7'h00);

        // R3 and R9: every channel/reference pair tracked while idle
        for (int v = 0; v < 128; v++) begin
            wr(7'(v));
            step();
            chk("R3", 7'(v));
        end

        // R10: last-cycle flag while tracking does not freeze
        conv_last = 1'b1;
        wr(7'h15);
        step();
        chk("R10", 7'h15);
        wr(7'h6B);
        step();
        chk("R10", 7'h6B);
        conv_last = 1'b0;
        no_wr();

        // conversions with lock windows of 0..5 cycles
        for (int len = 0; len < 6; len++) begin
            a  = 7'((len * 37 + 5) & 127);
            a2 = 7'((a + 7'h29) & 127);
            wr(a);
            start_req = 1'b1;
            step();
            chk("R4", a);
            start_req = 1'b0;
            conv_busy = 1'b1;
            wr(a2);
            step();
            chk("R4", a2);
            b = a2;
            for (int k = 0; k < len; k++) begin
                b = 7'((a2 + k * 13 + 1) & 127);
                wr(b);
                start_req = (k == 1);
                step();
                chk("R5", a2);
            end
            start_req = 1'b0;
            conv_last = 1'b1;
            if (len % 2 == 1) begin
                w = a2 ^ 7'h55;
                wr(w);
                exp = w;
            end else begin
                no_wr();
                exp = b;
            end
            step();
            chk((len % 2 == 1) ? "R7" : "R6", exp);
            conv_last = 1'b0;
            conv_busy = 1'b0;
            no_wr();
            step();
            chk("R2", exp);
            wr(exp ^ 7'h3C);
            step();
            chk("R7", exp ^ 7'h3C);
            no_wr();
        end

        // R8: abort by dropping busy
        wr(7'h11);
        start_req = 1'b1;
        step();
        start_req = 1'b0;
        conv_busy = 1'b1;
        no_wr();
        step();
        chk("R4", 7'h11);
        wr(7'h62);
        step();
        chk("R5", 7'h11);
        conv_busy = 1'b0;
        no_wr();
        step();
        chk("R8", 7'h62);
        wr(7'h0F);
        step();
        chk("R8", 7'h0F);
        no_wr();

        // R10: start request while armed has no extra effect
        wr(7'h20);
        start_req = 1'b1;
        step();
        conv_busy = 1'b1;
        wr(7'h21);
        step();
        chk("R10", 7'h21);
        start_req = 1'b0;
        wr(7'h22);
        step();
        chk("R10", 7'h21);
        conv_last = 1'b1;
        no_wr();
        step();
        chk("R6", 7'h22);
        conv_last = 1'b0;
        conv_busy = 1'b0;
        wr(7'h23);
        step();
        chk("R10", 7'h23);
        no_wr();

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule